// File: doc/BRIEF.md
# Constrained Event-to-Counter Allocator

This block hands out hardware event counters to requesters. It holds a bank of ten counters, numbered 0 to 9. A request names an 8-bit event code. Each code carries its own set of counters that may legally count it, and these sets are not uniform. Most codes are kept off counters 0 and 1. Some codes are confined to a few counters, and a few are confined to a single counter. The allocator looks up the legal set for the code and removes the counters already in use. It then grants the lowest-numbered counter that is left, and records that counter as taken.

The grant and the counter index are produced combinationally in the cycle of the request. The record of used counters changes on the following clock edge. A separate release port names a counter to free. When a release and a request arrive in the same cycle, the release takes effect first. A counter freed in that cycle can therefore be granted to the request in the same cycle. The allocator places one event at a time in arrival order and does not try to pack several events together.

Top module: `ctr_alloc`

## Requirements
- R1: A synchronous active-high reset marks every counter free. Right after reset, a request for event 0x33 is granted counter 2, and a request for event 0x02 is granted counter 0.
- R2: An event code that no rule below names may use only counters 2 to 9. No grant ever names counter 0 or 1 for such a code.
- R3: Event 0x02 may use counter 0 as well as counters 2 to 9.
- R4: Event 0x8c may use only counters 1 and 7.
- R5: Events 0x01, 0x97, 0x9a and 0x9f may use counter 7 and no other.
- R6: Events 0xf5, 0xf6, 0xf7 and 0xfd may use only counters 2, 4 and 6. Event 0xf8 may use counters 2 to 7.
- R7: The following events may use only counters 5, 6 and 7: 0x8d, 0x8e, 0x8f, 0x90, 0x93, 0x94, 0x95, 0x96, 0x98, 0x99, 0x9b, 0x9c, 0xbf, 0xc0, 0xc1, 0xc4, 0xc5, 0xc6, 0xc8, 0xca and 0xcb.
- R8: A valid request is granted the lowest-numbered counter that its event may use and that is free. `grant` and `grant_idx` are valid in the same cycle as the request, and that counter counts as used from the next clock edge on.
- R9: When none of the counters an event may use is free, `grant` stays low and `grant_idx` reads 0. The set of used counters does not change.
- R10: A release with an index from 0 to 9 frees that counter from the next edge on. A release with an index of 10 or more has no effect. Releasing a counter that is already free has no effect.
- R11: When a release and a request occur in the same cycle, the release is applied first. The request may be granted the counter being released.
- R12: While `req_valid` is low, `grant` is low and no counter is marked used, whatever `req_event` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Allocation request present this cycle |
| req_event | input | 8 | Event code of the request |
| rel_valid | input | 1 | Release present this cycle |
| rel_idx | input | 4 | Index of the counter to free |
| grant | output | 1 | Request granted this cycle |
| grant_idx | output | 4 | Granted counter index, 0 when there is no grant |

## Verification
The assertions assume that a requester does not hold `req_valid` across a clock edge for what it means to be a single event. Each cycle with `req_valid` high is a new allocation. The assertions also assume that a release index is meant to name a real counter, although indexes of 10 or more are tolerated. The bench raises `req_valid` for exactly one cycle per request, driving it at the falling edge and dropping it just after the rising edge. It issues releases on their own or paired with a single request, so every cycle's expected state follows from the sequence of requests and releases that came before it.

// File: rtl/ca_pkg.sv
package ca_pkg;
  localparam int unsigned CTR_N = 10;
  localparam int unsigned EVT_W = 8;
  localparam int unsigned IDX_W = $clog2(CTR_N);

  localparam logic [CTR_N-1:0] AFF_DEFAULT = CTR_N'(10'b11_1111_1100);
  localparam logic [CTR_N-1:0] AFF_CYCLES  = CTR_N'(10'b11_1111_1101);
  localparam logic [CTR_N-1:0] AFF_INSTR   = CTR_N'(10'b00_1000_0010);
  localparam logic [CTR_N-1:0] AFF_ONLY7   = CTR_N'(10'b00_1000_0000);
  localparam logic [CTR_N-1:0] AFF_EVENS   = CTR_N'(10'b00_0101_0100);
  localparam logic [CTR_N-1:0] AFF_TWO2SEV = CTR_N'(10'b00_1111_1100);
  localparam logic [CTR_N-1:0] AFF_HIGH3   = CTR_N'(10'b00_1110_0000);

  // Legal counter set per event code; exceptions override the default.
  function automatic logic [CTR_N-1:0] evt_affinity(input logic [EVT_W-1:0] code);
    logic [CTR_N-1:0] m;
    case (code) inside
      8'h02:                              m = AFF_CYCLES;
      8'h8c:                              m = AFF_INSTR;
      8'h01, 8'h97, 8'h9a, 8'h9f:         m = AFF_ONLY7;
      8'hf5, 8'hf6, 8'hf7, 8'hfd:         m = AFF_EVENS;
      8'hf8:                              m = AFF_TWO2SEV;
      [8'h8d:8'h90], [8'h93:8'h96], 8'h98, 8'h99, 8'h9b, 8'h9c,
      [8'hbf:8'hc1], [8'hc4:8'hc6], 8'hc8, 8'hca, 8'hcb:
                                          m = AFF_HIGH3;
      default:                            m = AFF_DEFAULT;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/ca_affinity.sv
module ca_affinity
  import ca_pkg::*;
(
  input  logic [EVT_W-1:0] evt_code,
  output logic [CTR_N-1:0] allowed
);
  always_comb allowed = evt_affinity(evt_code);
endmodule

// File: rtl/ca_pick.sv
module ca_pick #(
  parameter int unsigned WIDTH = 10,
  localparam int unsigned IW = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] cand,
  output logic             found,
  output logic [IW-1:0]    idx
);
  // Lowest set bit wins.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = 0; i < int'(WIDTH); i++) begin
      if (cand[i] && !found) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/ca_used_mask.sv
module ca_used_mask
  import ca_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             rel_valid,
  input  logic [IDX_W-1:0] rel_idx,
  input  logic             set_valid,
  input  logic [IDX_W-1:0] set_idx,
  output logic [CTR_N-1:0] used_q,
  output logic [CTR_N-1:0] used_eff
);
  logic [CTR_N-1:0] rel_hit;
  logic [CTR_N-1:0] set_hit;

  for (genvar g = 0; g < int'(CTR_N); g++) begin : g_dec
    assign rel_hit[g] = rel_valid && (rel_idx == IDX_W'(g));
    assign set_hit[g] = set_valid && (set_idx == IDX_W'(g));
  end

  // Release applies before this cycle's allocation.
  assign used_eff = used_q & ~rel_hit;

  always_ff @(posedge clk) begin
    if (rst) used_q <= '0;
    else     used_q <= used_eff | set_hit;
  end
endmodule

// File: rtl/ctr_alloc.sv
module ctr_alloc
  import ca_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [EVT_W-1:0] req_event,
  input  logic             rel_valid,
  input  logic [IDX_W-1:0] rel_idx,
  output logic             grant,
  output logic [IDX_W-1:0] grant_idx
);
  logic [CTR_N-1:0] aff_mask;
  logic [CTR_N-1:0] used_q;
  logic [CTR_N-1:0] used_eff;
  logic [CTR_N-1:0] cand;
  logic             found;
  logic [IDX_W-1:0] pick_idx;

  ca_affinity u_aff (.evt_code(req_event), .allowed(aff_mask));

  assign cand = req_valid ? (aff_mask & ~used_eff) : '0;

  ca_pick #(.WIDTH(CTR_N)) u_pick (.cand(cand), .found(found), .idx(pick_idx));

  assign grant     = found;
  assign grant_idx = found ? pick_idx : '0;

  ca_used_mask u_used (
    .clk(clk), .rst(rst),
    .rel_valid(rel_valid), .rel_idx(rel_idx),
    .set_valid(found), .set_idx(pick_idx),
    .used_q(used_q), .used_eff(used_eff)
  );
endmodule

// File: rtl/ca_chk.sv
module ca_chk
  import ca_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic [EVT_W-1:0] req_event,
  input logic             rel_valid,
  input logic [IDX_W-1:0] rel_idx,
  input logic             grant,
  input logic [IDX_W-1:0] grant_idx,
  input logic [CTR_N-1:0] aff_mask,
  input logic [CTR_N-1:0] used_q
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> used_q == '0);

  assert_grant_allowed_R2: assert property (@(posedge clk) disable iff (rst)
    grant |-> aff_mask[grant_idx]);

  assert_ctr0_cycles_R3: assert property (@(posedge clk) disable iff (rst)
    (grant && grant_idx == '0) |-> req_event == 8'h02);

  assert_grant_marks_R8: assert property (@(posedge clk) disable iff (rst)
    grant |=> used_q[$past(grant_idx)]);

  assert_grant_free_R11: assert property (@(posedge clk) disable iff (rst)
    grant |-> (!used_q[grant_idx] || (rel_valid && rel_idx == grant_idx)));

  assert_nogrant_idx_R9: assert property (@(posedge clk) disable iff (rst)
    !grant |-> grant_idx == '0);

  assert_release_R10: assert property (@(posedge clk) disable iff (rst)
    (rel_valid && 32'(rel_idx) < CTR_N && !(grant && grant_idx == rel_idx))
      |=> !used_q[$past(rel_idx)]);

  assert_idle_R12: assert property (@(posedge clk) disable iff (rst)
    !req_valid |-> !grant);
endmodule

bind ctr_alloc ca_chk u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_event(req_event),
  .rel_valid(rel_valid), .rel_idx(rel_idx), .grant(grant),
  .grant_idx(grant_idx), .aff_mask(aff_mask), .used_q(used_q)
);

// File: tb/ctr_alloc_test.sv
module ctr_alloc_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic [7:0] req_event = '0;
  logic       rel_valid = 1'b0;
  logic [3:0] rel_idx = '0;
  logic       grant;
  logic [3:0] grant_idx;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ctr_alloc uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_event(req_event),
    .rel_valid(rel_valid), .rel_idx(rel_idx),
    .grant(grant), .grant_idx(grant_idx)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
  endtask

  // One-cycle request; exp_idx < 0 means no grant expected.
  // Optional same-cycle release when rl >= 0.
  task automatic req(input logic [7:0] ev, input int exp_idx, input string tag,
                     input int rl = -1);
    @(negedge clk);
    req_valid = 1'b1; req_event = ev;
    if (rl >= 0) begin rel_valid = 1'b1; rel_idx = 4'(rl); end
    #1;
    chk(tag, int'(grant), (exp_idx >= 0) ? 1 : 0);
    chk(tag, int'(grant_idx), (exp_idx >= 0) ? exp_idx : 0);
    @(posedge clk); #1;
    req_valid = 1'b0; rel_valid = 1'b0;
  endtask

  task automatic rel(input int idx);
    @(negedge clk); rel_valid = 1'b1; rel_idx = 4'(idx);
    @(posedge clk); #1; rel_valid = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset();
    req(8'h33, 2, "R1 default after reset");
    req(8'h02, 0, "R1 cycles gets 0 after reset");
  endtask

  task automatic t_default_fill();
    do_reset();
    for (int i = 2; i < 10; i++) req(8'h40, i, "R2 R8 default fill");
    req(8'h40, -1, "R9 default exhausted");
    req(8'h02, 0, "R3 cycles on counter 0");
    req(8'h02, -1, "R9 cycles exhausted");
    req(8'h8c, 1, "R4 instructions on 1");
    req(8'h8c, -1, "R4 R9 instructions 7 taken");
  endtask

  task automatic t_cycles();
    do_reset();
    req(8'h02, 0, "R3 first cycles");
    req(8'h02, 2, "R3 second cycles");
  endtask

  task automatic t_instr();
    do_reset();
    req(8'h8c, 1, "R4 first");
    req(8'h8c, 7, "R4 second");
    req(8'h8c, -1, "R4 third fails");
    req(8'h01, -1, "R5 counter 7 taken");
  endtask

  task automatic t_single7();
    do_reset();
    req(8'h9f, 7, "R5 9f on 7");
    req(8'h9a, -1, "R5 9a blocked");
    req(8'h97, -1, "R5 97 blocked");
    req(8'h8c, 1, "R4 falls to 1");
  endtask

  task automatic t_evens();
    do_reset();
    req(8'hf5, 2, "R6 f5");
    req(8'hfd, 4, "R6 fd");
    req(8'hf6, 6, "R6 f6");
    req(8'hf7, -1, "R6 f7 exhausted");
    req(8'hf8, 3, "R6 f8 a");
    req(8'hf8, 5, "R6 f8 b");
    req(8'hf8, 7, "R6 f8 c");
    req(8'hf8, -1, "R6 f8 exhausted");
    req(8'h20, 8, "R2 default goes to 8");
  endtask

  task automatic t_group567();
    do_reset();
    req(8'h9b, 5, "R7 9b");
    req(8'hc0, 6, "R7 c0");
    req(8'hcb, 7, "R7 cb");
    req(8'h90, -1, "R7 90 exhausted");
    req(8'h01, -1, "R5 7 taken");
  endtask

  task automatic t_release();
    rel(6);
    req(8'hc4, 6, "R10 released 6 reused");
    rel(12);
    req(8'hc5, -1, "R10 out-of-range release ignored");
    rel(3);
    req(8'hc5, -1, "R10 free release no effect");
  endtask

  task automatic t_same_cycle();
    req(8'h8e, 5, "R11 same-cycle release", 5);
    req(8'h8e, -1, "R11 regranted counter held");
  endtask

  task automatic t_idle();
    do_reset();
    @(negedge clk); req_valid = 1'b0; req_event = 8'h02; #1;
    chk("R12 idle no grant", int'(grant), 0);
    @(posedge clk); #1;
    req(8'h02, 0, "R12 idle marked nothing");
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_default_fill();
    t_cycles();
    t_instr();
    t_single7();
    t_evens();
    t_group567();
    t_release();
    t_same_cycle();
    t_idle();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule